// File: doc/BRIEF.md
# Fetch-Block Branch Target Buffer

This block predicts, before decode, whether a 16-byte fetch block contains a taken branch and where that branch goes. Each cycle the front end presents a fetch address. The block reads one set of a 4-way set-associative store and compares the partial tag of every way. Each way also stores the byte offset of its branch inside the block. Several ways of one set can match the same block. The block then chooses the matching entry with the smallest stored offset that is not below the fetch offset. The result is the branch nearest to the fetch point that fetch has not yet passed.

Resolved branches come back on an update port. Taken branches are written into the buffer. They go into a free way first, and otherwise into the least recently used way of the set. Not-taken branches are dropped. Because tags are partial, a non-branch instruction can produce a hit. When decode finds such a false hit, it raises an invalidate request, and every way of that set is cleared.

Top module: `btb_predictor`

## Requirements
- R1: After a synchronous active-low reset, every lookup misses (`pred_hit` is 0).
- R2: The set index is address bits [12:4] and the partial tag is address bits [21:13]. A lookup hits only ways of the indexed set whose stored tag equals the fetch tag.
- R3: A taken update stores the branch. A lookup of the same address in any later cycle gives `pred_hit`=1, `pred_target` equal to the stored target and `pred_offset` equal to branch address bits [3:0].
- R4: Among the tag-matching ways of the set, only those with stored offset ≥ fetch address bits [3:0] are candidates. The output comes from the candidate with the smallest offset. When there is no candidate the lookup misses.
- R5: An update with the taken flag at 0 leaves the buffer unchanged.
- R6: A taken update whose set, tag and offset equal those of a valid entry overwrites that entry's target and uses no extra way.
- R7: A taken update that misses fills an empty way of its set if there is one. Otherwise it replaces the least recently used way. A lookup hit and an update both make the way they use the most recent.
- R8: An invalidate request clears all four ways of the set indexed by `inv_addr`[12:4] and leaves other sets unchanged.
- R9: When an invalidate and a taken update name the same set in one cycle, the invalidate wins and the update is dropped.
- R10: Lookups are combinational in the cycle the fetch address is presented. Updates and invalidations take effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_addr | input | 32 | Fetch-block lookup address |
| pred_hit | output | 1 | A taken branch is predicted in this block |
| pred_target | output | 32 | Predicted branch target |
| pred_offset | output | 4 | Byte offset of the chosen branch in the block |
| upd_valid | input | 1 | Update request |
| upd_addr | input | 32 | Resolved branch address |
| upd_target | input | 32 | Resolved branch target |
| upd_taken | input | 1 | Resolved branch was taken |
| inv_valid | input | 1 | False-hit invalidate request |
| inv_addr | input | 32 | Address whose set is invalidated |

## Verification
Lookup results are due in the same cycle the fetch address is applied. The bench therefore drives the address just after a falling edge and samples 5 ns later, before the next rising edge. Updates and invalidations are driven for exactly one rising edge, and their effect is checked by a lookup in a later cycle. One check also samples in the cycle of the update, to confirm that the update is not yet visible there. The bench holds each lookup address across one rising edge, so that the hit refreshes recency exactly when the LRU expectations assume it.

// File: rtl/btb_pkg.sv
// Shared sizing constants for the fetch-block branch target buffer.
// Assumes power-of-two set and way counts.
package btb_pkg;
    localparam int BTB_ADDR_W = 32;
    localparam int BTB_OFF_W  = 4;
    localparam int BTB_IDX_W  = 9;
    localparam int BTB_TAG_W  = 9;
    localparam int BTB_WAYS   = 4;
endpackage

// File: rtl/btb_lru.sv
// Per-set age ordering of the ways (0 = most recent, WAYS-1 = oldest).
// One way of one set can be touched per cycle. A second port reports the
// oldest way of any queried set. Assumes WAYS is a power of two.
module btb_lru #(
    parameter int SETS  = 512,
    parameter int WAYS  = 4,
    parameter int SET_W = $clog2(SETS),
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] vict_set,
    output logic [WAY_W-1:0] vict_way
);
    localparam int AGE_W = WAY_W;

    logic [AGE_W-1:0] age_q [SETS][WAYS];

    // Age update: touched way becomes 0, younger ways age by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= AGE_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_q[touch_set][w] <= '0;
                else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
            end
        end
    end

    // Victim choice: the way carrying the oldest age.
    always_comb begin
        vict_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (age_q[vict_set][w] == AGE_W'(WAYS - 1))
                vict_way = WAY_W'(w);
    end

    // Checker state: remember the last touched set.
    logic             chk_touched_q;
    logic [SET_W-1:0] chk_set_q;
    logic [WAYS-1:0]  chk_seen;

    // Capture the set touched last cycle for the ordering check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_touched_q <= 1'b0;
            chk_set_q     <= '0;
        end else begin
            chk_touched_q <= touch_en;
            chk_set_q     <= touch_set;
        end
    end

    // Mark which age values are present in the checked set.
    always_comb begin
        chk_seen = '0;
        for (int w = 0; w < WAYS; w++)
            chk_seen[age_q[chk_set_q][w]] = 1'b1;
    end

    // R7: ages of a touched set stay a permutation, so one victim exists.
    p_age_perm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chk_touched_q |-> ($countones(chk_seen) == WAYS));
endmodule

// File: rtl/btb_pick.sv
// Offset selection among the ways of one set. A way is a candidate when it
// matches and its stored offset is not below the fetch offset. The candidate
// with the smallest offset wins. Purely combinational.
module btb_pick #(
    parameter int WAYS   = 4,
    parameter int OFF_W  = 4,
    parameter int ADDR_W = 32,
    parameter int WAY_W  = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]   match,
    input  logic [OFF_W-1:0]  way_off [WAYS],
    input  logic [ADDR_W-1:0] way_tgt [WAYS],
    input  logic [OFF_W-1:0]  fetch_off,
    output logic              hit,
    output logic [WAY_W-1:0]  sel_way,
    output logic [OFF_W-1:0]  sel_off,
    output logic [ADDR_W-1:0] sel_tgt
);
    // Nearest-branch search over all ways.
    always_comb begin
        hit     = 1'b0;
        sel_way = '0;
        sel_off = '0;
        sel_tgt = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w] && way_off[w] >= fetch_off && (!hit || way_off[w] < sel_off)) begin
                hit     = 1'b1;
                sel_way = WAY_W'(w);
                sel_off = way_off[w];
                sel_tgt = way_tgt[w];
            end
        end
    end
endmodule

// File: rtl/btb_predictor.sv
// Set-associative branch target buffer looked up with a fetch-block address.
// Lookup is combinational. Updates and invalidations are written at the
// clock edge. Reset clears valid bits only; tag, offset and target arrays
// are not reset.
module btb_predictor
    import btb_pkg::*;
#(
    parameter int ADDR_W = BTB_ADDR_W,
    parameter int OFF_W  = BTB_OFF_W,
    parameter int IDX_W  = BTB_IDX_W,
    parameter int TAG_W  = BTB_TAG_W,
    parameter int WAYS   = BTB_WAYS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              pred_hit,
    output logic [ADDR_W-1:0] pred_target,
    output logic [OFF_W-1:0]  pred_offset,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              upd_taken,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr
);
    localparam int SETS  = 1 << IDX_W;
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_L = OFF_W + IDX_W;

    logic [SETS-1:0][WAYS-1:0] valid_q;
    logic [TAG_W-1:0]  tag_q [SETS][WAYS];
    logic [OFF_W-1:0]  off_q [SETS][WAYS];
    logic [ADDR_W-1:0] tgt_q [SETS][WAYS];

    logic [IDX_W-1:0] f_set, u_set, i_set;
    logic [TAG_W-1:0] f_tag, u_tag;
    logic [OFF_W-1:0] u_off;

    assign f_set = fetch_addr[OFF_W +: IDX_W];
    assign f_tag = fetch_addr[TAG_L +: TAG_W];
    assign u_set = upd_addr[OFF_W +: IDX_W];
    assign u_tag = upd_addr[TAG_L +: TAG_W];
    assign u_off = upd_addr[OFF_W-1:0];
    assign i_set = inv_addr[OFF_W +: IDX_W];

    // Lookup side: tag match per way of the fetch set.
    logic [WAYS-1:0]   f_match;
    logic [OFF_W-1:0]  f_off [WAYS];
    logic [ADDR_W-1:0] f_tgt [WAYS];
    logic [WAY_W-1:0]  f_way;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            f_match[w] = valid_q[f_set][w] && (tag_q[f_set][w] == f_tag);
            f_off[w]   = off_q[f_set][w];
            f_tgt[w]   = tgt_q[f_set][w];
        end
    end

    btb_pick #(.WAYS(WAYS), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) pick_i (
        .match     (f_match),
        .way_off   (f_off),
        .way_tgt   (f_tgt),
        .fetch_off (fetch_addr[OFF_W-1:0]),
        .hit       (pred_hit),
        .sel_way   (f_way),
        .sel_off   (pred_offset),
        .sel_tgt   (pred_target)
    );

    // Update side: find an exact entry, else a free way, else the LRU way.
    logic             u_hit, u_free;
    logic [WAY_W-1:0] u_hit_way, u_free_way, u_vict_way, wr_way;
    logic             wr_en;

    always_comb begin
        u_hit = 1'b0; u_hit_way = '0;
        u_free = 1'b0; u_free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (valid_q[u_set][w] && tag_q[u_set][w] == u_tag && off_q[u_set][w] == u_off) begin
                u_hit = 1'b1; u_hit_way = WAY_W'(w);
            end
            if (!valid_q[u_set][w]) begin
                u_free = 1'b1; u_free_way = WAY_W'(w);
            end
        end
        wr_way = u_hit ? u_hit_way : (u_free ? u_free_way : u_vict_way);
        wr_en  = upd_valid && upd_taken && !(inv_valid && i_set == u_set);
    end

    btb_lru #(.SETS(SETS), .WAYS(WAYS)) lru_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (wr_en || pred_hit),
        .touch_set (wr_en ? u_set : f_set),
        .touch_way (wr_en ? wr_way : f_way),
        .vict_set  (u_set),
        .vict_way  (u_vict_way)
    );

    // Valid bits: reset clear, set-wide invalidate, allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (inv_valid) valid_q[i_set] <= '0;
            if (wr_en)     valid_q[u_set][wr_way] <= 1'b1;
        end
    end

    // Entry payload write on a taken update.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[u_set][wr_way] <= u_tag;
            off_q[u_set][wr_way] <= u_off;
            tgt_q[u_set][wr_way] <= upd_target;
        end
    end

    // Checker state: last cycle's write and invalidate.
    logic              chk_wr_q, chk_inv_q;
    logic [ADDR_W-1:0] chk_wr_addr_q, chk_wr_tgt_q;
    logic [IDX_W-1:0]  chk_inv_set_q;

    // Capture last cycle's write and invalidate for the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_wr_q <= 1'b0; chk_inv_q <= 1'b0;
            chk_wr_addr_q <= '0; chk_wr_tgt_q <= '0; chk_inv_set_q <= '0;
        end else begin
            chk_wr_q      <= wr_en;
            chk_wr_addr_q <= upd_addr;
            chk_wr_tgt_q  <= upd_target;
            chk_inv_q     <= inv_valid;
            chk_inv_set_q <= i_set;
        end
    end

    // R4: a chosen branch never lies before the fetch point.
    p_offset_not_behind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pred_hit |-> (pred_offset >= fetch_addr[OFF_W-1:0]));

    // R3: a branch written last cycle is found at its own address.
    p_alloc_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_wr_q && fetch_addr == chk_wr_addr_q) |-> (pred_hit && pred_target == chk_wr_tgt_q));

    // R8: the set invalidated last cycle holds nothing.
    p_inv_clears_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_inv_q && f_set == chk_inv_set_q) |-> !pred_hit);
endmodule

// File: tb/btb_predictor_tb_top.sv
// Scoreboard bench: the driver pushes expected lookup results, the monitor
// pops and compares them at the sampling point.
module btb_predictor_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_addr, upd_addr, upd_target, inv_addr;
    logic        upd_valid, upd_taken, inv_valid;
    logic        pred_hit;
    logic [31:0] pred_target;
    logic [3:0]  pred_offset;

    localparam logic [31:0] IDLE = 32'h003F_FFF0;

    always #10 clk = ~clk;

    btb_predictor dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr),
        .pred_hit(pred_hit), .pred_target(pred_target), .pred_offset(pred_offset),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_target(upd_target),
        .upd_taken(upd_taken), .inv_valid(inv_valid), .inv_addr(inv_addr)
    );

    typedef struct {
        bit          hit;
        logic [31:0] tgt;
        logic [3:0]  off;
        string       req;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    event mon_ev;

    function automatic logic [31:0] mk(input int tag, input int set, input int off);
        return {10'b0, 9'(tag), 9'(set), 4'(off)};
    endfunction

    // Monitor: compare the outputs against the oldest expected item.
    initial begin
        forever begin
            @(mon_ev);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_chk++;
                if (pred_hit !== e.hit ||
                    (e.hit && (pred_target !== e.tgt || pred_offset !== e.off))) begin
                    n_fail++;
                    $display("FAIL %s: got hit=%0b tgt=%h off=%0d, expected hit=%0b tgt=%h off=%0d",
                             e.req, pred_hit, pred_target, pred_offset, e.hit, e.tgt, e.off);
                end
            end
        end
    end

    task automatic sample(input bit h, input logic [31:0] t, input int o, input string req);
        exp_t e;
        e.hit = h; e.tgt = t; e.off = 4'(o); e.req = req;
        sb_q.push_back(e);
        #5 -> mon_ev;
        #1;
    endtask

    // Lookup held across one rising edge so that a hit refreshes recency.
    task automatic look(input logic [31:0] a, input bit h, input logic [31:0] t,
                        input int o, input string req);
        @(negedge clk);
        fetch_addr = a;
        sample(h, t, o, req);
        @(negedge clk);
        fetch_addr = IDLE;
    endtask

    task automatic upd(input logic [31:0] a, input logic [31:0] t, input bit tk);
        @(negedge clk);
        upd_valid = 1'b1; upd_addr = a; upd_target = t; upd_taken = tk;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic inv(input logic [31:0] a);
        @(negedge clk);
        inv_valid = 1'b1; inv_addr = a;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        fetch_addr = IDLE; upd_valid = 0; upd_addr = 0; upd_target = 0;
        upd_taken = 0; inv_valid = 0; inv_addr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset.
        look(mk(1, 5, 0), 0, 0, 0, "R1 reset empty");
        look(mk(0, 0, 0), 0, 0, 0, "R1 reset empty set0");

        // R10: update not visible in its own cycle, visible after the edge.
        @(negedge clk);
        fetch_addr = mk(2, 3, 6);
        upd_valid = 1; upd_addr = mk(2, 3, 6); upd_target = 32'h1000_0006; upd_taken = 1;
        sample(0, 0, 0, "R10 same-cycle miss");
        @(negedge clk);
        upd_valid = 0;
        sample(1, 32'h1000_0006, 6, "R10 next-cycle hit");
        @(negedge clk);
        fetch_addr = IDLE;

        // R3 / R2: allocate and look up; tag or set mismatch misses.
        look(mk(2, 3, 6), 1, 32'h1000_0006, 6, "R3 stored branch");
        look(mk(2, 3, 0), 1, 32'h1000_0006, 6, "R3 block start finds branch");
        look(mk(9, 3, 6), 0, 0, 0, "R2 other tag same set");
        look(mk(2, 4, 6), 0, 0, 0, "R2 same tag other set");

        // R4: offset selection among several matching ways.
        upd(mk(3, 7, 9),  32'hA000_0009, 1);
        upd(mk(3, 7, 2),  32'hA000_0002, 1);
        upd(mk(3, 7, 14), 32'hA000_000E, 1);
        look(mk(3, 7, 0),  1, 32'hA000_0002, 2,  "R4 fetch 0 picks 2");
        look(mk(3, 7, 3),  1, 32'hA000_0009, 9,  "R4 fetch 3 picks 9");
        look(mk(3, 7, 9),  1, 32'hA000_0009, 9,  "R4 fetch 9 picks 9");
        look(mk(3, 7, 10), 1, 32'hA000_000E, 14, "R4 fetch 10 picks 14");
        look(mk(3, 7, 15), 0, 0, 0,              "R4 past last branch misses");

        // R5: not-taken update is dropped.
        upd(mk(4, 30, 1), 32'hDEAD_0001, 0);
        look(mk(4, 30, 1), 0, 0, 0, "R5 not-taken ignored");

        // R6: overwrite in place, then three more fit beside it.
        upd(mk(5, 20, 4), 32'h2000_0001, 1);
        upd(mk(5, 20, 4), 32'h2000_0002, 1);
        upd(mk(6, 20, 0), 32'h2600_0000, 1);
        upd(mk(7, 20, 0), 32'h2700_0000, 1);
        upd(mk(8, 20, 0), 32'h2800_0000, 1);
        look(mk(5, 20, 4), 1, 32'h2000_0002, 4, "R6 target overwritten");
        look(mk(6, 20, 0), 1, 32'h2600_0000, 0, "R6 no extra way used");
        look(mk(8, 20, 0), 1, 32'h2800_0000, 0, "R6 fourth way kept");

        // R7: fill four ways, refresh the oldest, fifth evicts the next oldest.
        for (int k = 1; k <= 4; k++) upd(mk(k, 5, 0), 32'h5000_0000 + k, 1);
        look(mk(1, 5, 0), 1, 32'h5000_0001, 0, "R7 refresh oldest");
        upd(mk(15, 5, 0), 32'h5000_000F, 1);
        look(mk(2, 5, 0),  0, 0, 0,              "R7 LRU way evicted");
        look(mk(1, 5, 0),  1, 32'h5000_0001, 0,  "R7 refreshed way kept");
        look(mk(3, 5, 0),  1, 32'h5000_0003, 0,  "R7 way kept");
        look(mk(15, 5, 0), 1, 32'h5000_000F, 0,  "R7 new entry present");

        // R8: invalidate clears a whole set only.
        inv(mk(85, 7, 11));
        look(mk(3, 7, 0), 0, 0, 0, "R8 set cleared off0");
        look(mk(3, 7, 10), 0, 0, 0, "R8 set cleared off10");
        look(mk(3, 5, 0), 1, 32'h5000_0003, 0, "R8 other set kept");

        // R9: invalidate beats an update to the same set.
        upd(mk(1, 40, 3), 32'h4000_0003, 1);
        @(negedge clk);
        inv_valid = 1; inv_addr = mk(9, 40, 0);
        upd_valid = 1; upd_addr = mk(2, 40, 5); upd_target = 32'h4000_0005; upd_taken = 1;
        @(negedge clk);
        inv_valid = 0; upd_valid = 0;
        look(mk(2, 40, 5), 0, 0, 0, "R9 colliding update dropped");
        look(mk(1, 40, 0), 0, 0, 0, "R9 prior entry cleared");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule